// File: doc/BRIEF.md
# Streaming CRC-20 Key Hasher

This block reduces a binary key of variable length to a 20-bit table index. Key bytes arrive packed into 32-bit words on a valid/ready stream. The first word of a key carries a start marker and the last word carries an end marker. A 20-bit CRC register absorbs one whole word per clock through an unrolled next-state network.

The final word of a key may hold fewer than 32 meaningful bits. A 5-bit count sent with that word chooses how many of its most significant bits enter the CRC. The hash appears on a valid-qualified output one cycle after the final word is taken, and it stays there until the next key completes.

Typical keys run from 72 to 288 bits, which is 3 to 9 words. The logic also handles keys of any other length, including single-word keys. The polynomial is a parameter.

Top module: `crc_key_hasher`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `hash_valid_o` is 0 and `hash_o` is 0. From that first cycle on, `word_ready_o` is 1 and stays 1.
- R2: The hash is a 20-bit CRC with generator x^20 + x^3 + 1 (`POLY` = 20'h00009). It is preset to all ones, takes each word's bits most significant first, and is reported with no final inversion. One serial step is: feedback = crc[19] XOR bit; crc = crc << 1; if the feedback is 1, crc ^= `POLY`.
- R3: On an end-marked word, `word_nbits_i` values 1 to 31 feed only bits [31:32-n] into the CRC, and 0 feeds all 32 bits. The remaining bits have no effect. On words without an end marker, `word_nbits_i` is ignored and all 32 bits are used.
- R4: One word is accepted on every clock in which `word_valid_i` is high. There are no stalls inside a key or between keys.
- R5: `hash_valid_o` is high for exactly one cycle, the cycle after an end-marked word of an active key is accepted. `hash_o` holds its value until the next result replaces it.
- R6: A start-marked word may arrive in the cycle right after an end-marked word, and both keys hash correctly.
- R7: A start-marked word that arrives inside an active key discards the partial CRC and begins a new key from the preset.
- R8: A word without a start marker that arrives while no key is active is ignored. This holds even if it carries an end marker: it produces no result and leaves `hash_o` unchanged. Clock cycles with `word_valid_i` low inside a key leave the key's CRC unchanged.
- R9: A word that carries both markers is a complete one-word key, and it obeys the R3 count rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Input word present |
| word_ready_o | output | 1 | Word can be accepted |
| word_data_i | input | 32 | Key word, first bit in position 31 |
| word_sok_i | input | 1 | Word opens a key |
| word_eok_i | input | 1 | Word closes a key |
| word_nbits_i | input | 5 | Valid leading bits in the closing word, 0 means 32 |
| hash_valid_o | output | 1 | One-cycle strobe, new hash present |
| hash_o | output | 20 | Hash of the most recent completed key |

## Verification
Two events can share a cycle at the input. In the first, the closing word of one key is followed at once by the opening word of the next, so the result register is loading while the CRC register is being preset. In the second, a start marker lands inside a live key, so a restart meets an active accumulation.

The bench provokes both on purpose: it sweeps every key length from 3 to 9 words back to back, and it injects restarts partway through keys. Each emitted hash is compared with a bitwise serial CRC that the bench computes over exactly the key's valid bits. In every other cycle the bench also checks that `hash_valid_o` is low and `hash_o` is unchanged.

// File: rtl/crc_hash_pkg.sv
package crc_hash_pkg;
  typedef enum logic {KEY_IDLE = 1'b0, KEY_BUSY = 1'b1} key_state_e;
  localparam int unsigned HASH_W_DEF = 20;
  localparam int unsigned WORD_W_DEF = 32;
  localparam logic [19:0] POLY_DEF   = 20'h00009; // x^20 + x^3 + 1, primitive
endpackage

// File: rtl/crc_next.sv
module crc_next #(
  parameter int unsigned CRC_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter logic [CRC_W-1:0] POLY = 20'h00009,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,  // 0 = full word
  output logic [CRC_W-1:0]  crc_o
);
  logic [CNT_W:0]     nlen;
  logic [CRC_W-1:0]   st [0:DATA_W];

  assign nlen  = (nbits_i == '0) ? (CNT_W+1)'(DATA_W) : {1'b0, nbits_i};
  assign st[0] = crc_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    logic             fb;
    logic [CRC_W-1:0] nx;
    assign fb        = st[g][CRC_W-1] ^ data_i[DATA_W-1-g];
    assign nx        = {st[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    assign st[g+1]   = (nlen > (CNT_W+1)'(g)) ? nx : st[g];
  end

  assign crc_o = st[DATA_W];
endmodule

// File: rtl/crc_key_ctrl.sv
module crc_key_ctrl
  import crc_hash_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic sok_i,
  input  logic eok_i,
  output logic use_o,   // word feeds the CRC
  output logic seed_o   // start from preset
);
  key_state_e state_q;

  assign use_o  = accept_i & (sok_i | (state_q == KEY_BUSY));
  assign seed_o = sok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= KEY_IDLE;
    else if (use_o) state_q <= eok_i ? KEY_IDLE : KEY_BUSY;
  end

  // R6: closing word frees the tracker for the next cycle
  assert_close_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && (sok_i || state_q == KEY_BUSY) && eok_i) |=> (state_q == KEY_IDLE));
  // R7: any start marker leaves an open key unless closed
  assert_open_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && sok_i && !eok_i) |=> (state_q == KEY_BUSY));
endmodule

// File: rtl/crc_key_hasher.sv
module crc_key_hasher
  import crc_hash_pkg::*;
#(
  parameter int unsigned HASH_W = HASH_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter logic [HASH_W-1:0] POLY = POLY_DEF,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic              word_sok_i,
  input  logic              word_eok_i,
  input  logic [CNT_W-1:0]  word_nbits_i,
  output logic              hash_valid_o,
  output logic [HASH_W-1:0] hash_o
);
  logic              ready_q, accept, use_w, seed_w;
  logic [HASH_W-1:0] crc_q, crc_base, crc_nxt, hash_q;
  logic [CNT_W-1:0]  nbits_eff;
  logic              hvld_q;

  assign accept    = word_valid_i & ready_q;
  assign crc_base  = seed_w ? '1 : crc_q;
  assign nbits_eff = word_eok_i ? word_nbits_i : '0;

  crc_key_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .sok_i    (word_sok_i),
    .eok_i    (word_eok_i),
    .use_o    (use_w),
    .seed_o   (seed_w)
  );

  crc_next #(.CRC_W(HASH_W), .DATA_W(WORD_W), .POLY(POLY)) u_next (
    .crc_i   (crc_base),
    .data_i  (word_data_i),
    .nbits_i (nbits_eff),
    .crc_o   (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      crc_q   <= '1;
      hash_q  <= '0;
      hvld_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      hvld_q  <= use_w & word_eok_i;
      if (use_w) crc_q <= crc_nxt;
      if (use_w && word_eok_i) hash_q <= crc_nxt;
    end
  end

  assign word_ready_o = ready_q;
  assign hash_valid_o = hvld_q;
  assign hash_o       = hash_q;

  // R5: a result only follows a closing word
  assert_strobe_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o |-> $past(word_valid_i && word_eok_i));
  // R5: hash holds between results
  assert_hash_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hash_valid_o |-> $stable(hash_o));
  // R8: ignored words leave the accumulator untouched
  assert_ignored_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !use_w) |=> $stable(crc_q));
  // R4: once up, ready never drops
  assert_ready_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(word_ready_o) |-> word_ready_o);
endmodule

// File: tb/tb_crc_key_hasher.sv
module tb_crc_key_hasher;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_data_i = '0;
  logic        word_sok_i = 1'b0;
  logic        word_eok_i = 1'b0;
  logic [4:0]  word_nbits_i = '0;
  logic        hash_valid_o;
  logic [19:0] hash_o;

  int          errors = 0;
  int          checks = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [19:0] ref_crc;
  logic [19:0] last_hash = '0;

  always #2.5 clk_i = ~clk_i;

  crc_key_hasher dut (
    .clk_i, .rst_ni, .word_valid_i, .word_ready_o, .word_data_i,
    .word_sok_i, .word_eok_i, .word_nbits_i, .hash_valid_o, .hash_o
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [19:0] ref_step(input logic [19:0] c, input logic [31:0] d, input int n);
    logic [19:0] r = c;
    for (int i = 0; i < n; i++) begin
      logic fb = r[19] ^ d[31-i];
      r = {r[18:0], 1'b0};
      if (fb) r = r ^ 20'h00009;
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample one negedge later (after the accepting posedge)
  task automatic send(input logic [31:0] d, input logic s, input logic e, input logic [4:0] nb,
                      input logic exp_v, input logic [19:0] exp_h, input string req);
    word_valid_i = 1'b1; word_data_i = d; word_sok_i = s; word_eok_i = e; word_nbits_i = nb;
    @(negedge clk_i);
    word_valid_i = 1'b0;
    check(hash_valid_o == exp_v, {req, " strobe"}, 32'(hash_valid_o), 32'(exp_v));
    if (exp_v) last_hash = exp_h;
    check(hash_o == last_hash, {req, " hash"}, 32'(hash_o), 32'(last_hash));
  endtask

  task automatic idle_cycle(input string req);
    word_valid_i = 1'b0;
    @(negedge clk_i);
    check(hash_valid_o == 1'b0, {req, " idle strobe"}, 32'(hash_valid_o), 32'h0);
    check(hash_o == last_hash, {req, " idle hash"}, 32'(hash_o), 32'(last_hash));
  endtask

  // full key; bubble_at >= 0 inserts an idle cycle before that word
  task automatic run_key(input int len, input int nlast, input int bubble_at, input string req);
    ref_crc = '1;
    for (int w = 0; w < len; w++) begin
      logic        last = (w == len - 1);
      logic [4:0]  nb;
      int          n;
      rng = next_rand(rng);
      n  = last ? ((nlast == 0) ? 32 : nlast) : 32;
      ref_crc = ref_step(ref_crc, rng, n);
      nb = last ? 5'(nlast) : rng[12:8]; // R3: count on inner words is noise
      if (w == bubble_at) idle_cycle({req, " R8"});
      send(rng, w == 0, last, nb, last, ref_crc, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(hash_valid_o == 1'b0, "R1 strobe in reset", 32'(hash_valid_o), 32'h0);
    check(hash_o == '0, "R1 hash in reset", 32'(hash_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(word_ready_o == 1'b1, "R1 ready", 32'(word_ready_o), 32'h1);
    check(hash_valid_o == 1'b0, "R1 strobe after reset", 32'(hash_valid_o), 32'h0);
    check(hash_o == '0, "R1 hash after reset", 32'(hash_o), 32'h0);

    // R2 R3 R4 R5 R6: every length 3..9 against every tail count, back to back
    for (int len = 3; len <= 9; len++)
      for (int nl = 0; nl < 32; nl++)
        run_key(len, nl, -1, "R2/R3/R6");

    // R3: same leading bits with different tail junk give the same hash
    begin
      logic [19:0] h1;
      ref_crc = '1;
      ref_crc = ref_step(ref_crc, 32'hA5A5_0000, 32);
      send(32'hA5A5_0000, 1'b1, 1'b0, 5'd3, 1'b0, '0, "R3");
      ref_crc = ref_step(ref_crc, 32'hC300_0000, 10);
      send(32'hC300_0000, 1'b0, 1'b1, 5'd10, 1'b1, ref_crc, "R3");
      h1 = ref_crc;
      send(32'hA5A5_0000, 1'b1, 1'b0, 5'd17, 1'b0, '0, "R3");
      send(32'hC33F_FFFF, 1'b0, 1'b1, 5'd10, 1'b1, h1, "R3 tail ignored");
    end

    // R8: valid-low gaps inside keys
    for (int b = 1; b < 6; b++) run_key(6, b * 5, b, "R8 gap");

    // R8: stray words outside any key, including one with end marker
    send(32'hDEAD_BEEF, 1'b0, 1'b1, 5'd0, 1'b0, '0, "R8 stray eok");
    send(32'h0BAD_F00D, 1'b0, 1'b0, 5'd0, 1'b0, '0, "R8 stray");
    run_key(4, 7, -1, "R8 after stray");

    // R7: restart in the middle of a key
    for (int k = 1; k < 5; k++) begin
      for (int w = 0; w < k; w++) begin
        rng = next_rand(rng);
        send(rng, w == 0, 1'b0, 5'd0, 1'b0, '0, "R7 partial");
      end
      run_key(5, k + 11, -1, "R7 restart");
    end

    // R9: single-word keys, all counts
    for (int nl = 0; nl < 32; nl++) begin
      rng = next_rand(rng);
      ref_crc = ref_step(20'hFFFFF, rng, (nl == 0) ? 32 : nl);
      send(rng, 1'b1, 1'b1, 5'(nl), 1'b1, ref_crc, "R9");
    end

    // R5: hash holds over idle cycles
    repeat (4) idle_cycle("R5 hold");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule